// File: doc/BRIEF.md
# Time-Multiplexed Filtered Digital Input

This block collects sixteen digital inputs over one shared 8-bit external bus. A timer produces a single-cycle sampling pulse. The timer's period is set by the caller. Each pulse starts a short fetch sequence. The block first raises the select strobe for the low byte and latches the bus. It then raises the strobe for the high byte and latches the bus again. One cycle later, every one of the sixteen bits takes one step of its own counter-based glitch filter.

The filtered 16-bit word is held in a register for downstream logic. Each bit has its own filter threshold, so slow and noisy inputs can be tuned separately. A run control gates the whole block. While it is low, the block sits idle with the strobes low, the filters reset and the output word cleared. The external bus must return to a stable value within one clock of a strobe rising. The period setting must be at least 3, so that each fetch sequence completes before the next pulse.

Top module: `tdm_din_filter`

## Requirements
- R1: While `run` is 0, after the next clock edge both strobes are 0, `dout` is 0 and all filter counters are cleared.
- R2: While `run` is 1, consecutive rising edges of `sel_lo` are exactly `period_set + 1` clock cycles apart.
- R3: `sel_lo` is high for exactly one cycle per sampling pulse. It is followed immediately by `sel_hi` high for exactly one cycle. The two strobes are never high together.
- R4: The bus value present in the `sel_lo` cycle feeds bits 7:0. The bus value present in the `sel_hi` cycle feeds bits 15:8.
- R5: `dout` changes only at the clock edge one cycle after the `sel_hi` cycle ends (the filter step).
- R6: With threshold L for a bit (field `limit_set[4*i +: 4]` for bit i), the output bit takes a new level at the L+1-th consecutive filter step in which the fetched bit differs from the output. A step in which they agree resets that bit's count to zero.
- R7: A threshold of 0 makes the bit pass-through: it equals the fetched value after every filter step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = operate, 0 = idle and clear |
| period_set | input | PER_W | Sampling period minus one, in cycles (at least 3) |
| limit_set | input | 16*LIM_W | Per-bit filter thresholds, bit i in field i |
| din | input | 8 | Shared external input bus |
| sel_lo | output | 1 | Strobe selecting inputs 7:0 onto the bus |
| sel_hi | output | 1 | Strobe selecting inputs 15:8 onto the bus |
| dout | output | 16 | Filtered input word |

## Verification
A corrupted counter in the period timer shows up as a wrong spacing between `sel_lo` pulses, visible by the second pulse. A broken fetch-sequence state shows up within one cycle, as overlapping or missing strobes or as a byte landing in the wrong half of `dout`. A wrong per-bit filter count is only visible when a threshold is crossed, up to L+1 sampling periods later. The reference model therefore compares `dout` after every filter step while thresholds and input patterns vary.

// File: rtl/tdm_din_filter.sv
module tdm_din_filter #(
  parameter int PER_W = 8,
  parameter int LIM_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PER_W-1:0]    period_set,
  input  logic [16*LIM_W-1:0] limit_set,
  input  logic [7:0]          din,
  output logic                sel_lo,
  output logic                sel_hi,
  output logic [15:0]         dout
);

  localparam logic [1:0] S_IDLE = 2'd0, S_LO = 2'd1, S_HI = 2'd2, S_FILT = 2'd3;

  logic [PER_W-1:0] tick_cnt;
  logic [1:0]       state;
  logic [15:0]      raw;
  logic             pulse;

  assign pulse = run && (tick_cnt == period_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_cnt <= '0;
    else if (!run || pulse) tick_cnt <= '0;
    else tick_cnt <= tick_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sel_lo <= 1'b0;
      sel_hi <= 1'b0;
      raw    <= '0;
    end else if (!run) begin
      state  <= S_IDLE;
      sel_lo <= 1'b0;
      sel_hi <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (pulse) begin state <= S_LO; sel_lo <= 1'b1; end
        S_LO: begin
          raw[7:0] <= din;
          state    <= S_HI;
          sel_lo   <= 1'b0;
          sel_hi   <= 1'b1;
        end
        S_HI: begin
          raw[15:8] <= din;
          state     <= S_FILT;
          sel_hi    <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wire step = run && (state == S_FILT);

  for (genvar i = 0; i < 16; i++) begin : g_bit
    logic [LIM_W-1:0] cnt;
    wire  [LIM_W-1:0] lim = limit_set[i*LIM_W +: LIM_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt     <= '0;
        dout[i] <= 1'b0;
      end else if (!run) begin
        cnt     <= '0;
        dout[i] <= 1'b0;
      end else if (step) begin
        if (raw[i] == dout[i]) cnt <= '0;
        else if (cnt >= lim) begin
          cnt     <= '0;
          dout[i] <= raw[i];
        end else cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdm_din_filter_chk.sv
module tdm_din_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        sel_lo,
  input logic        sel_hi,
  input logic [15:0] dout
);

  p_strobe_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_lo && sel_hi));

  p_hi_follows_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel_lo) |=> (sel_hi && !sel_lo));

  p_stop_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (dout == 16'h0 && !sel_lo && !sel_hi));

  p_dout_only_on_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(sel_hi, 2)) |-> $stable(dout));

endmodule

bind tdm_din_filter tdm_din_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run),
  .sel_lo(sel_lo), .sel_hi(sel_hi), .dout(dout)
);

// File: tb/tdm_din_filter_bench.sv
module tdm_din_filter_bench;
  localparam int CLK_NS = 10;
  localparam int PER_W = 8;
  localparam int LIM_W = 4;

  logic clk = 0, rst_n = 0, run = 0;
  logic [PER_W-1:0] period_set = 8'd9;
  logic [16*LIM_W-1:0] limit_set = '0;
  logic [15:0] word = '0;
  logic [7:0] din;
  logic sel_lo, sel_hi;
  logic [15:0] dout;

  int nchk = 0, nfail = 0;

  always #(CLK_NS/2) clk = ~clk;

  // external mux model: bench drives the selected half onto the bus
  assign din = sel_lo ? word[7:0] : sel_hi ? word[15:8] : 8'hA5;

  tdm_din_filter #(.PER_W(PER_W), .LIM_W(LIM_W)) u_tdm_din_filter (
    .clk(clk), .rst_n(rst_n), .run(run), .period_set(period_set),
    .limit_set(limit_set), .din(din), .sel_lo(sel_lo), .sel_hi(sel_hi), .dout(dout));

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  logic [15:0] mf = '0;
  int mc[16];
  logic [7:0] lo_seen, hi_seen;
  logic prev_run = 0, prev_lo = 0, prev_hi = 0, cmp_pend = 0, have_gap = 0;
  int gap = 0;

  function automatic logic [15:0] filt_step(input logic [15:0] f, input logic [15:0] r);
    logic [15:0] nf = f;
    for (int i = 0; i < 16; i++) begin
      int lim = int'(limit_set[i*LIM_W +: LIM_W]);
      if (r[i] == f[i]) mc[i] = 0;
      else if (mc[i] >= lim) begin mc[i] = 0; nf[i] = r[i]; end
      else mc[i] = mc[i] + 1;
    end
    return nf;
  endfunction

  always @(negedge clk) begin
    if (!prev_run) begin
      mf = '0; cmp_pend = 0; have_gap = 0; gap = 0;
      for (int i = 0; i < 16; i++) mc[i] = 0;
      if (rst_n) begin
        check(dout == 16'h0, "R1 dout", dout, 0);
        check(!sel_lo && !sel_hi, "R1 strobes", {sel_lo, sel_hi}, 0);
      end
    end else begin
      check(!(sel_lo && sel_hi), "R3 exclusive", {sel_lo, sel_hi}, 0);
      if (prev_lo && !sel_lo) check(sel_hi, "R3 hi after lo", sel_hi, 1);
      if (prev_hi) check(!sel_hi, "R3 hi one cycle", sel_hi, 0);
      if (cmp_pend) begin
        check(dout == mf, "R4/R6/R7 dout", dout, mf);
        cmp_pend = 0;
      end else if (gap > 0) begin
        // outside the step edge dout must hold (R5)
        check(dout == mf, "R5 dout hold", dout, mf);
      end
      if (sel_lo && !prev_lo) begin
        if (have_gap) check(gap == int'(period_set) + 1, "R2 period", gap, int'(period_set) + 1);
        have_gap = 1; gap = 0;
      end
      gap++;
      if (sel_lo) lo_seen = din;
      if (sel_hi) hi_seen = din;
      if (prev_hi && !sel_hi) begin
        mf = filt_step(mf, {hi_seen, lo_seen});
        cmp_pend = 1;
      end
    end
    prev_run = run; prev_lo = sel_lo; prev_hi = sel_hi;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic stop_and_set(input logic [PER_W-1:0] p, input logic [16*LIM_W-1:0] l);
    run = 0; wait_cycles(3);
    period_set = p; limit_set = l;
    run = 1;
  endtask

  task automatic random_phase(input int cycles, input int maxhold);
    int left = cycles;
    while (left > 0) begin
      int h = 1 + int'($urandom_range(maxhold - 1));
      word = 16'($urandom);
      wait_cycles(h);
      left -= h;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    wait_cycles(3);
    check(dout == 16'h0 && !sel_lo && !sel_hi, "R1 reset", {dout, sel_lo, sel_hi}, 0);
    rst_n = 1;
    wait_cycles(20);
    check(!sel_lo && !sel_hi && dout == 0, "R1 idle before run", {dout, sel_lo, sel_hi}, 0);

    // R7 pass-through, fixed pattern then random
    word = 16'hC35A;
    stop_and_set(8'd9, '0);
    wait_cycles(60);
    check(dout == 16'hC35A, "R7 pass-through word", dout, 16'hC35A);
    random_phase(2000, 30);

    // R6 threshold 2: a two-period glitch must be rejected
    word = 16'h0000;
    stop_and_set(8'd9, {16{4'd2}});
    wait_cycles(50);
    word = 16'hFFFF;
    wait_cycles(20);
    word = 16'h0000;
    wait_cycles(40);
    check(dout == 16'h0000, "R6 glitch rejected", dout, 0);
    word = 16'h8001;
    wait_cycles(60);
    check(dout == 16'h8001, "R6 sustained change accepted", dout, 16'h8001);

    // stop mid-operation clears output (R1)
    run = 0; wait_cycles(2);
    check(dout == 16'h0, "R1 stop clears", dout, 0);

    // minimum period and random settings
    for (int k = 0; k < 12; k++) begin
      logic [16*LIM_W-1:0] l;
      for (int i = 0; i < 16; i++) l[i*LIM_W +: LIM_W] = LIM_W'($urandom_range(3));
      stop_and_set(PER_W'(3 + $urandom_range(12)), (k == 0) ? '0 : l);
      random_phase(3000, (k % 2) ? 8 : 60);
    end
    run = 0; wait_cycles(4);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule